// File: doc/BRIEF.md
# SRAM Wake-Up and DLL Lock Sequencer

This block sits on the controller side of a source-synchronous SRAM interface. It decides when read and write commands may go out. Two separate waits have to be met first. The first is a one-time start-up interval of running memory clock after power-on. The second is a lock interval, measured in memory clock edges, that the memory's on-die DLL needs after each of its resets. The block raises `cmd_ready` only when both are satisfied, and the command path uses it as a gate. The block also drives the memory's DLL enable pin, which follows a software request to turn the DLL off.

A DLL reset has two causes. One is the enable pin being driven low. The other is a pause of the memory clock that lasts longer than a fixed time. Pauses are found by a timeout counter that runs on the reference clock and is fed by a per-cycle strobe marking each observed memory clock edge. When either cause occurs, `cmd_ready` falls in the same cycle and the lock count starts over. The start-up interval is never repeated.

A parameter chooses how the two waits relate. With the default, the lock count runs at the same time as the start-up interval, so a DLL enabled early is covered by the start-up wait. With the other setting, the lock count only begins once the start-up interval has ended.

Top module: `sram_wakeup_seq`

## Requirements
- R1: While `rst_n` is low, `cmd_ready` is 0 and `dll_en_pin` is 0.
- R2: `dll_en_pin` equals the inverse of `dll_off_req` sampled at the previous rising edge of `clk`.
- R3: The memory clock counts as stopped once `mclk_edge` has been 0 for more than STOP_LIMIT consecutive reference cycles, where STOP_LIMIT = ceil(STOP_NS*1000/REF_PERIOD_PS). A gap of STOP_LIMIT cycles or fewer has no effect on `cmd_ready`. The clock also counts as stopped from reset until the first strobe.
- R4: `cmd_ready` goes low in the same cycle in which `dll_en_pin` goes low or the clock becomes stopped.
- R5: After a DLL reset ends (the pin is high and the clock is running again), `cmd_ready` stays low until LOCK_EDGES cycles with `mclk_edge` = 1 have been counted. Cycles without a strobe do not count.
- R6: The start-up interval is INIT_CYCLES = ceil(INIT_NS*1000/REF_PERIOD_PS) reference cycles of running clock. It is held at zero while the clock is stopped. Once it has completed, it never applies again.
- R7: With LOCK_AFTER_INIT = 0, the lock count and the start-up count run at the same time, and `cmd_ready` rises in the first cycle in which both are complete.
- R8: With LOCK_AFTER_INIT = 1, the lock count starts only in the cycle after the start-up interval completes.
- R9: A stop of the memory clock does not change `dll_en_pin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (timebase) |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mclk_edge | input | 1 | One per reference cycle in which a memory clock edge was observed (already synchronized) |
| dll_off_req | input | 1 | Software request to disable the memory DLL |
| dll_en_pin | output | 1 | Drive for the memory DLL enable pin (1 = DLL enabled) |
| cmd_ready | output | 1 | Gate for the read and write command interface |

## Verification
The bench builds two instances with a 10 ns reference period, INIT_NS = 400, STOP_NS = 30 and LOCK_EDGES = 16. These give a 40-cycle start-up interval, a 3-cycle stop limit and a 16-edge lock count. With such small counts, every transition can be checked at its exact cycle within a few hundred clocks. These transitions include a 3-cycle pause that must be tolerated, a 4-cycle pause that must be caught, recovery without a second start-up wait, and a lock count fed by half-rate strobes. One instance uses LOCK_AFTER_INIT = 0 and the other uses 1, so the concurrent and serial orderings are compared on the same stimulus.

// File: rtl/wake_pkg.sv
package wake_pkg;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   typedef enum logic [1:0] {
      WK_COLD = 2'd0,
      WK_INIT = 2'd1,
      WK_LOCK = 2'd2,
      WK_RUN  = 2'd3
   } wake_phase_e;

endpackage

// File: rtl/wake_clk_watch.sv
module wake_clk_watch #(
   parameter int STOP_LIMIT = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   output logic stopped_o
);
   localparam int SAT = STOP_LIMIT + 1;
   localparam int GW  = $clog2(SAT + 1);
   localparam logic [GW-1:0] SAT_V = GW'(SAT);

   if (STOP_LIMIT < 1) begin : g_bad_limit
      $error("wake_clk_watch: STOP_LIMIT must be at least 1");
   end

   logic [GW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= SAT_V;
      end else if (edge_i) begin
         gap_q <= '0;
      end else if (gap_q != SAT_V) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   assign stopped_o = (gap_q == SAT_V);

   p_edge_clears_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      edge_i |=> !stopped_o);

   p_stop_needs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stopped_o) |-> !$past(edge_i));

endmodule

// File: rtl/wake_init_timer.sv
module wake_init_timer #(
   parameter int INIT_CYCLES = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CW = $clog2(INIT_CYCLES + 1);
   localparam logic [CW-1:0] END_V = CW'(INIT_CYCLES);

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("wake_init_timer: INIT_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q != END_V) begin
         if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign done_o = (cnt_q == END_V);

   p_init_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);

   p_init_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !done_o) |=> (cnt_q == '0));

endmodule

// File: rtl/wake_lock_counter.sv
module wake_lock_counter #(
   parameter int LOCK_EDGES      = 2048,
   parameter bit LOCK_AFTER_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   input  logic dll_en_i,
   input  logic stopped_i,
   input  logic init_done_i,
   output logic done_o
);
   localparam int LW = $clog2(LOCK_EDGES + 1);
   localparam logic [LW-1:0] END_V = LW'(LOCK_EDGES);

   if (LOCK_EDGES < 1) begin : g_bad_lock
      $error("wake_lock_counter: LOCK_EDGES must be at least 1");
   end

   logic          go;
   logic          clr;
   logic [LW-1:0] cnt_q;

   if (LOCK_AFTER_INIT) begin : g_serial
      assign go = init_done_i;
   end else begin : g_overlap
      assign go = 1'b1;
   end

   assign clr = !dll_en_i || stopped_i || !go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (edge_i && cnt_q != END_V) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = (cnt_q == END_V);

   p_lock_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt_q) && cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));

   p_lock_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dll_en_i || stopped_i) |=> (cnt_q == '0));

endmodule

// File: rtl/sram_wakeup_seq.sv
module sram_wakeup_seq
   import wake_pkg::*;
#(
   parameter int REF_PERIOD_PS   = 2000,
   parameter int STOP_NS         = 30,
   parameter int INIT_NS         = 20000,
   parameter int LOCK_EDGES      = 2048,
   parameter bit LOCK_AFTER_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mclk_edge,
   input  logic dll_off_req,
   output logic dll_en_pin,
   output logic cmd_ready
);
   localparam int STOP_LIMIT  = ceil_div(STOP_NS * 1000, REF_PERIOD_PS);
   localparam int INIT_CYCLES = ceil_div(INIT_NS * 1000, REF_PERIOD_PS);

   if (REF_PERIOD_PS < 1) begin : g_bad_period
      $error("sram_wakeup_seq: REF_PERIOD_PS must be positive");
   end

   logic        dll_en_q;
   logic        stopped;
   logic        init_done;
   logic        lock_done;
   wake_phase_e phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dll_en_q <= 1'b0;
      end else begin
         dll_en_q <= !dll_off_req;
      end
   end

   wake_clk_watch #(
      .STOP_LIMIT(STOP_LIMIT)
   ) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_i   (mclk_edge),
      .stopped_o(stopped)
   );

   wake_init_timer #(
      .INIT_CYCLES(INIT_CYCLES)
   ) u_init (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (!stopped),
      .done_o(init_done)
   );

   wake_lock_counter #(
      .LOCK_EDGES     (LOCK_EDGES),
      .LOCK_AFTER_INIT(LOCK_AFTER_INIT)
   ) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_i     (mclk_edge),
      .dll_en_i   (dll_en_q),
      .stopped_i  (stopped),
      .init_done_i(init_done),
      .done_o     (lock_done)
   );

   always_comb begin
      if (!init_done) begin
         phase = stopped ? WK_COLD : WK_INIT;
      end else if (!lock_done || !dll_en_q || stopped) begin
         phase = WK_LOCK;
      end else begin
         phase = WK_RUN;
      end
   end

   assign dll_en_pin = dll_en_q;
   assign cmd_ready  = (phase == WK_RUN);

   p_ready_needs_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> dll_en_pin);

   p_rise_after_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_ready) |-> (lock_done && init_done));

   p_pin_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dll_off_req |=> !dll_en_pin);

   p_stop_keeps_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !dll_off_req) |=> dll_en_pin);

endmodule

// File: tb/sram_wakeup_seq_test.sv
`timescale 1ns/1ps
module sram_wakeup_seq_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mclk_edge = 1'b0;
   logic dll_off_req = 1'b0;
   logic pin_a, rdy_a, pin_b, rdy_b;

   int cyc = 0;
   int tests = 0;
   int fails = 0;

   typedef struct {
      int    at;
      int    sel;
      bit    val;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_wakeup_seq #(
      .REF_PERIOD_PS(10000), .STOP_NS(30), .INIT_NS(400),
      .LOCK_EDGES(16), .LOCK_AFTER_INIT(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .mclk_edge(mclk_edge),
      .dll_off_req(dll_off_req), .dll_en_pin(pin_a), .cmd_ready(rdy_a)
   );

   sram_wakeup_seq #(
      .REF_PERIOD_PS(10000), .STOP_NS(30), .INIT_NS(400),
      .LOCK_EDGES(16), .LOCK_AFTER_INIT(1'b1)
   ) uut_ser (
      .clk(clk), .rst_n(rst_n), .mclk_edge(mclk_edge),
      .dll_off_req(dll_off_req), .dll_en_pin(pin_b), .cmd_ready(rdy_b)
   );

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic push(input int at, input int sel, input bit val, input string tag);
      exp_t e;
      e.at = at; e.sel = sel; e.val = val; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic at_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   function automatic bit observe(input int sel);
      case (sel)
         0: return rdy_a;
         1: return rdy_b;
         default: return pin_a;
      endcase
   endfunction

   // monitor: compares scoreboard items at their cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_t e;
         bit act;
         e = sb.pop_front();
         act = observe(e.sel);
         tests++;
         if (act !== e.val) begin
            fails++;
            $display("FAIL %s cycle %0d sel %0d: actual %0b expected %0b",
                     e.tag, cyc, e.sel, act, e.val);
         end
      end
   end

   initial begin
      repeat (4000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R1 reset state
      push(0, 0, 1'b0, "R1"); push(0, 1, 1'b0, "R1"); push(0, 2, 1'b0, "R1");
      // R2 pin rises one cycle after reset release
      push(1, 2, 1'b1, "R2");
      // R6 lock done at 22 but start-up interval not yet
      push(21, 0, 1'b0, "R6"); push(45, 0, 1'b0, "R6");
      // R7 concurrent: ready at 46; R8 serial still waiting
      push(46, 0, 1'b1, "R7"); push(46, 1, 1'b0, "R8");
      push(61, 1, 1'b0, "R8"); push(62, 1, 1'b1, "R8");
      // R3 three-cycle gap tolerated
      push(72, 0, 1'b1, "R3"); push(73, 0, 1'b1, "R3");
      push(74, 0, 1'b1, "R3"); push(74, 1, 1'b1, "R3");
      // R3/R4 four-cycle gap detected, ready drops
      push(83, 0, 1'b1, "R3"); push(84, 0, 1'b0, "R4"); push(84, 1, 1'b0, "R4");
      push(86, 2, 1'b1, "R9"); push(88, 0, 1'b0, "R3");
      // R5 relock after stop, R6 no second start-up wait
      push(106, 0, 1'b0, "R5"); push(106, 1, 1'b0, "R5");
      push(107, 0, 1'b1, "R6"); push(107, 1, 1'b1, "R5");
      // R2/R4 software DLL disable
      push(120, 2, 1'b1, "R2"); push(121, 2, 1'b0, "R2"); push(121, 0, 1'b0, "R4");
      push(131, 2, 1'b1, "R2");
      push(146, 0, 1'b0, "R5"); push(147, 0, 1'b1, "R5");
      // R5 lock counts strobes, not reference cycles (half-rate strobes)
      push(201, 0, 1'b0, "R5"); push(202, 0, 1'b1, "R5"); push(202, 1, 1'b1, "R5");

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      at_cyc(5);   mclk_edge = 1'b1;
      at_cyc(70);  mclk_edge = 1'b0;
      at_cyc(73);  mclk_edge = 1'b1;
      at_cyc(80);  mclk_edge = 1'b0;
      at_cyc(90);  mclk_edge = 1'b1;
      at_cyc(120); dll_off_req = 1'b1;
      at_cyc(130); dll_off_req = 1'b0;
      at_cyc(160); dll_off_req = 1'b1;
      at_cyc(170); dll_off_req = 1'b0; mclk_edge = 1'b0;
      for (int k = 171; k < 205; k++) begin
         at_cyc(k);
         mclk_edge = k[0];
      end
      at_cyc(205); mclk_edge = 1'b1;
      at_cyc(215);
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule